// File: doc/BRIEF.md
# Staged Filter Coefficient Loader

This block holds the horizontal anti-alias coefficient tables for the luma (Y) and chroma (UV) planes. Software programs them over a simple register bus with a single-cycle write strobe. Each plane has five 32-bit staging words and a trigger register. Writing a staging word only updates the staging copy. Writing the trigger commits all five staged words together as one 160-bit entry at the plane's current entry pointer, and the pointer then advances.

A full programming pass is sixteen stage-then-trigger rounds. After the sixteenth commit since the last pointer restart, the plane's done flag rises. Writing 0 to the enable bit of the control register sends both pointers back to entry 0, so a new pass can begin. The filter datapath fetches entries through one registered read port per plane, using a 4-bit index.

Top module: `coef_stage_loader`

## Requirements
- R1: A write to a staging word changes no table entry. The staged data reaches the table only on a later trigger write.
- R2: A trigger write stores the plane's five staged words into the entry at the current pointer. Staging word k lands in bits [32k+31:32k] of the 160-bit entry, so word 0 is least significant. The staging words keep their values after the trigger.
- R3: Each trigger advances that plane's entry pointer by one. The pointer wraps from 15 back to 0, and a 17th commit overwrites entry 0.
- R4: The data value written with a trigger has no effect. Only the write strobe matters.
- R5: The Y and UV planes are independent. A write to one plane's staging, trigger or read index never alters the other plane's table, pointer or done flag.
- R6: A write to the control register with bit 0 = 0 sets both pointers to 0 and clears both done flags. A write with bit 0 = 1 leaves them unchanged. `filt_en` shows the last value written to bit 0.
- R7: A plane's done flag becomes 1 on the cycle after its 16th commit since reset or the last pointer restart. It stays 1 until the next restart.
- R8: A read data port shows the entry addressed by its index one clock after the index is presented.
- R9: After reset, both pointers are 0, both done flags are 0, every table entry reads 0 and `filt_en` is 0.
- R10: The address map is as follows. Y staging words 0..4 are at addresses 0..4, and the Y trigger is at 5. UV staging words 0..4 are at addresses 6..10, and the UV trigger is at 11. The control register is at 12. Writes to addresses 13..15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Write data |
| y_rd_idx | input | 4 | Luma table read index |
| y_rd_data | output | 160 | Luma entry, registered |
| uv_rd_idx | input | 4 | Chroma table read index |
| uv_rd_data | output | 160 | Chroma entry, registered |
| y_done | output | 1 | Luma table fully programmed |
| uv_done | output | 1 | Chroma table fully programmed |
| filt_en | output | 1 | Enable bit from the control register |

## Verification
The bench builds the block with its default DEPTH of 16, five words per entry and 32-bit words. With these values, a full pass, the done transition after exactly sixteen commits and the wrap onto entry 0 all occur within a few hundred bus writes. Random writes over all sixteen addresses, including the three unmapped ones and frequent control writes, mix restarts into passes that are only partly complete. This covers restarts part-way through a pass and restarts after the pass has finished.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NWORDS   = 5;
  localparam int unsigned ENTRY_W  = WORD_W * NWORDS;
  localparam int unsigned NPLANES  = 2;
  localparam int unsigned PLANE_SPAN = NWORDS + 1;
  localparam int unsigned BUS_AW   = 4;
  localparam int unsigned CTRL_ADDR = NPLANES * PLANE_SPAN;

  // Word address of staging word w (w == NWORDS selects the trigger) of plane p
  function automatic logic [BUS_AW-1:0] reg_addr(input int unsigned p, input int unsigned w);
    return BUS_AW'(p * PLANE_SPAN + w);
  endfunction

  // Pointer advance with wrap for any depth
  function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/coef_addr_dec.sv
module coef_addr_dec
  import coef_pkg::*;
(
  input  logic                      wr_en,
  input  logic [BUS_AW-1:0]         wr_addr,
  output logic [NPLANES*NWORDS-1:0] stage_we,
  output logic [NPLANES-1:0]        trig_we,
  output logic                      ctrl_we
);
  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      assign stage_we[p*NWORDS + w] = wr_en && (wr_addr == reg_addr(p, w));
    end
    assign trig_we[p] = wr_en && (wr_addr == reg_addr(p, NWORDS));
  end
  assign ctrl_we = wr_en && (wr_addr == BUS_AW'(CTRL_ADDR));

  // At most one register strobe per bus write
  always_comb begin
    AST_ONE_STROBE: assert ($onehot0({stage_we, trig_we, ctrl_we})); // R10
  end
endmodule

// File: rtl/coef_plane.sv
module coef_plane
  import coef_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NWORDS-1:0]  stage_we,
  input  logic               trig,
  input  logic               clr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               done
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0]  stg [NWORDS];
  logic [ENTRY_W-1:0] stg_flat;
  logic [ENTRY_W-1:0] tbl [DEPTH];
  logic [IDX_W-1:0]   ptr;
  logic [CNT_W-1:0]   cnt;
  logic               commit;

  assign commit = trig;

  for (genvar w = 0; w < NWORDS; w++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stg[w] <= '0;
      else if (stage_we[w]) stg[w] <= wr_data;
    end
    assign stg_flat[w*WORD_W +: WORD_W] = stg[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (commit) begin
      tbl[ptr] <= stg_flat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
    end else if (clr) begin
      ptr <= '0;
      cnt <= '0;
    end else if (commit) begin
      ptr <= IDX_W'(ptr_next(int'(ptr), DEPTH));
      if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= tbl[rd_idx];
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !clr && ptr == IDX_W'(DEPTH-1) |=> ptr == '0); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !clr |=> $stable(ptr) && $stable(cnt)); // R1
  AST_CLR_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0 && !done); // R6
  AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !clr && cnt == CNT_W'(DEPTH-1) |=> done); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> done); // R7
endmodule

// File: rtl/coef_stage_loader.sv
module coef_stage_loader
  import coef_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BUS_AW-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   y_rd_idx,
  output logic [ENTRY_W-1:0] y_rd_data,
  input  logic [IDX_W-1:0]   uv_rd_idx,
  output logic [ENTRY_W-1:0] uv_rd_data,
  output logic               y_done,
  output logic               uv_done,
  output logic               filt_en
);
  logic [NPLANES*NWORDS-1:0] stage_we;
  logic [NPLANES-1:0]        trig_we;
  logic                      ctrl_we;
  logic                      ptr_clr;
  logic [IDX_W-1:0]          rd_idx_a  [NPLANES];
  logic [ENTRY_W-1:0]        rd_data_a [NPLANES];
  logic [NPLANES-1:0]        done_a;

  coef_addr_dec u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .stage_we (stage_we),
    .trig_we  (trig_we),
    .ctrl_we  (ctrl_we)
  );

  assign ptr_clr = ctrl_we && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       filt_en <= 1'b0;
    else if (ctrl_we) filt_en <= wr_data[0];
  end

  assign rd_idx_a[0] = y_rd_idx;
  assign rd_idx_a[1] = uv_rd_idx;

  for (genvar p = 0; p < NPLANES; p++) begin : g_pl
    coef_plane #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_plane (
      .clk      (clk),
      .rst_n    (rst_n),
      .stage_we (stage_we[p*NWORDS +: NWORDS]),
      .trig     (trig_we[p]),
      .clr      (ptr_clr),
      .wr_data  (wr_data),
      .rd_idx   (rd_idx_a[p]),
      .rd_data  (rd_data_a[p]),
      .done     (done_a[p])
    );
  end

  assign y_rd_data  = rd_data_a[0];
  assign uv_rd_data = rd_data_a[1];
  assign y_done     = done_a[0];
  assign uv_done    = done_a[1];

  AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> filt_en == $past(wr_data[0])); // R6
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr > BUS_AW'(CTRL_ADDR) |=> $stable(filt_en) && $stable(done_a)); // R10
endmodule

// File: tb/coef_stage_loader_bench.sv
`timescale 1ns/1ps
module coef_stage_loader_bench;
  localparam int DEPTH = 16;
  localparam int NW = 5;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_en = 0;
  logic [3:0]   wr_addr = 0;
  logic [31:0]  wr_data = 0;
  logic [3:0]   y_rd_idx = 0, uv_rd_idx = 0;
  logic [159:0] y_rd_data, uv_rd_data;
  logic         y_done, uv_done, filt_en;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [159:0] m_tbl [2][DEPTH];
  logic [31:0]  m_stg [2][NW];
  int           m_ptr [2];
  int           m_cnt [2];
  bit           m_en;

  always #2.5 clk = ~clk;

  coef_stage_loader u_coef_stage_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .y_rd_idx(y_rd_idx), .y_rd_data(y_rd_data), .uv_rd_idx(uv_rd_idx),
    .uv_rd_data(uv_rd_data), .y_done(y_done), .uv_done(uv_done), .filt_en(filt_en)
  );

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [159:0] staged(input int p);
    logic [159:0] e;
    for (int k = 0; k < NW; k++) e[k*32 +: 32] = m_stg[p][k];
    return e;
  endfunction

  // Expected effect of one bus write, from the address map
  function automatic void model_write(input int a, input logic [31:0] d);
    if (a < 12) begin
      int p = a / 6;
      int w = a % 6;
      if (w < NW) m_stg[p][w] = d;
      else begin
        m_tbl[p][m_ptr[p]] = staged(p);
        m_ptr[p] = (m_ptr[p] + 1) % DEPTH;
        if (m_cnt[p] < DEPTH) m_cnt[p]++;
      end
    end else if (a == 12) begin
      m_en = d[0];
      if (!d[0]) begin
        m_ptr[0] = 0; m_ptr[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      end
    end
  endfunction

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_write(a, d);
  endtask

  // Present both indices, compare one clock later, plus flags
  task automatic read_chk(input int yi, input int ui, input string req);
    y_rd_idx = 4'(yi); uv_rd_idx = 4'(ui);
    @(negedge clk);
    chk(y_rd_data == m_tbl[0][yi], {req, " Y entry"}, y_rd_data, m_tbl[0][yi]);
    chk(uv_rd_data == m_tbl[1][ui], {req, " UV entry"}, uv_rd_data, m_tbl[1][ui]);
    chk(y_done == (m_cnt[0] == DEPTH), {req, " Y done"}, 160'(y_done), 160'(m_cnt[0] == DEPTH));
    chk(uv_done == (m_cnt[1] == DEPTH), {req, " UV done"}, 160'(uv_done), 160'(m_cnt[1] == DEPTH));
    chk(filt_en == m_en, {req, " enable"}, 160'(filt_en), 160'(m_en));
  endtask

  task automatic commit_entry(input int p, input logic [31:0] base);
    for (int k = 0; k < NW; k++) bus_wr(p*6 + k, base + 32'(k));
    bus_wr(p*6 + 5, $urandom);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < DEPTH; i++) m_tbl[p][i] = '0;
      for (int k = 0; k < NW; k++) m_stg[p][k] = '0;
      m_ptr[p] = 0; m_cnt[p] = 0;
    end
    m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    for (int i = 0; i < DEPTH; i++) read_chk(i, DEPTH-1-i, "R9");

    // R1: staging alone leaves the table untouched
    for (int k = 0; k < NW; k++) bus_wr(k, 32'hA000_0000 + 32'(k));
    read_chk(0, 0, "R1");
    // R2: trigger commits word k to bits [32k+31:32k]
    bus_wr(5, 32'hFFFF_FFFF);
    read_chk(0, 0, "R2");
    chk(y_rd_data[63:32] == 32'hA000_0001, "R2 word1 position", y_rd_data, 160'(32'hA000_0001));
    // R4: second trigger with different data, same staging, same entry content
    bus_wr(5, 32'h0);
    read_chk(1, 0, "R4");
    chk(y_rd_data == staged(0), "R4 trigger data ignored", y_rd_data, staged(0));
    // R5: UV untouched by Y programming
    read_chk(0, 1, "R5");

    // R7: fill Y to 16 commits; done only after the 16th
    bus_wr(12, 32'h1);
    for (int n = 2; n < DEPTH; n++) begin
      commit_entry(0, 32'h100 * 32'(n));
      read_chk(n, 0, "R7");
    end
    chk(y_done == 1, "R7 done after 16", 160'(y_done), 160'(1));
    chk(uv_done == 0, "R5 UV done stays low", 160'(uv_done), 160'(0));
    // R3: 17th commit wraps onto entry 0
    commit_entry(0, 32'h5555_0000);
    read_chk(0, 0, "R3");
    read_chk(1, 0, "R3");
    // R6: enable=1 write keeps pointer, enable=0 restarts
    bus_wr(12, 32'h1);
    commit_entry(0, 32'h6666_0000);
    read_chk(1, 0, "R6");
    bus_wr(12, 32'h0);
    read_chk(1, 0, "R6");
    commit_entry(0, 32'h7777_0000);
    read_chk(0, 0, "R6");
    // R10: unmapped addresses have no effect
    for (int a = 13; a < 16; a++) bus_wr(a, $urandom);
    read_chk(1, 0, "R10");
    commit_entry(1, 32'h8888_0000);
    read_chk(1, 0, "R10");

    // Random mix over all addresses; R8 latency checked each step
    for (int n = 0; n < 4000; n++) begin
      int a = ($urandom % 8 == 0) ? 12 : int'($urandom % 16);
      bus_wr(a, $urandom);
      read_chk(int'($urandom % DEPTH), int'($urandom % DEPTH), "R8");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule